// File: doc/BRIEF.md
# Dual-Channel Optical Frame Receiver

This block takes one serial frame at a time from two optical channels that carry the same bit: a visible-light bit and an infrared bit. It samples them once per bit time, marked by a one-cycle bit strobe. While software has set the run bit in the control word, the block looks for a start mark. In a start mark the two channels deliberately disagree. After the start mark it shifts in a device ID, a byte-length code and a data field. It checks the data field with a bit-serial CRC-16, then looks for a stop mark, which is the complement of the start mark.

Outside the two mark hunts, the infrared channel acts as a check on the light channel: any bit time in which they differ aborts the frame. The results are held in three registers: an 8-bit status word, a 16-bit received-ID word and a 128-bit data word. A 16-bit control word holds the auto-rearm bit, the run bit, a target-ID load bit and the target ID. A read-back copy of the control word shows the run bit as the receiver leaves it.

Top module: `dual_optic_rx`

## Requirements
- R1: After a synchronous reset, `status`, `rx_id`, `rx_data` and `ctrl_rd` are all zero, and the receiver is idle.
- R2: A `ctrl_wr` pulse stores `ctrl_wdata`, and `ctrl_rd` returns it with bits 15..14 forced to zero. The bits are: 13 = auto-rearm, 12 = run, 11 = load, 10..0 = target ID. The target ID is latched only by a write that has bit 11 set, and it is kept across later writes that have bit 11 clear.
- R3: While run is set, four consecutive strobed bit times with `ir_in`=1 and `light_in` = 0,0,0,1 begin a frame. While run is clear, no frame is received.
- R4: The next 11 bits are the ID, taken from `light_in` MSB first. `rx_id` then becomes the ID zero-extended to 16 bits. If the ID differs from the target ID, `status` is loaded with 0x00 and the receiver returns to start hunting with run unchanged.
- R5: A 4-bit length code follows, MSB first. It gives the data field size in bytes, including the two CRC bytes. The data field places length×8 bits into `rx_data`, starting at bit 127 and moving downward. Bits that are not written are zero from the start mark on.
- R6: The CRC uses polynomial 0x1021 with an initial value of zero. It runs over every data-field bit, CRC bytes included. Status bit 5 is set exactly when the final remainder is non-zero.
- R7: After the data field, four bit times with `ir_in`=0 and `light_in` = 1,1,1,0 complete the frame. They load `status` = {1, 1, crc_error, 0, length} (bit 7 = ID match, 6 = received, 5 = CRC error, 4 = false signal, 3..0 = length).
- R8: During the ID, length or data phase, a strobed bit time with `light_in` ≠ `ir_in` aborts the frame. The abort loads `status` = {ID matched so far, 0, 0, 1, length code if already complete else 0} and returns to start hunting. Channel disagreement during either mark hunt is ignored.
- R9: A length code of 0, 1 or 2 never completes the data phase. After length×8 bits, further strobed bits are not stored, and only a false-signal abort or clearing run leaves the phase.
- R10: A completed frame clears run unless auto-rearm is set. With auto-rearm set, run stays set and the receiver at once hunts for the next start mark. Clearing run by a write returns the receiver to idle from any phase.
- R11: `status` changes only on a strobed bit that completes or aborts a frame, or on a `stat_clr` pulse, which zeroes it.
- R12: Channel values in cycles without `bit_en` have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a bit time |
| light_in | input | 1 | Visible-light channel bit |
| ir_in | input | 1 | Infrared channel bit |
| ctrl_wr | input | 1 | Control word write pulse |
| ctrl_wdata | input | 16 | Control word value to write |
| stat_clr | input | 1 | Clears the status word |
| ctrl_rd | output | 16 | Control word read-back with effective run bit |
| status | output | 8 | Status word: ID match, received, CRC error, false signal, length |
| rx_id | output | 16 | Last received ID, zero-extended |
| rx_data | output | 128 | Data field, first bit at bit 127 |

## Verification
The hardest state to reach from the ports is the receiver being partway through a frame when something goes wrong. This covers a channel disagreement inside the ID, length or data field, and a short length code that leaves the data phase waiting for good. The stimulus builds whole frames bit by bit, with a CRC computed in the bench. It then cuts a frame off at a chosen bit position by sending one disagreeing bit, and it sweeps every length code from 0 to 15 with both correct and corrupted CRC bytes. Between strobes it drives inverted channel values, so any use of unstrobed samples would change the outcome of every frame.

// File: rtl/dorx_pkg.sv
package dorx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEEK_SOF,
    PH_ID,
    PH_LEN,
    PH_DATA,
    PH_SEEK_EOF
  } phase_t;

  // control word bit positions
  localparam int CW_AUTO = 13;
  localparam int CW_RUN  = 12;
  localparam int CW_LOAD = 11;

  // status word bit positions above the length field
  localparam int ST_IDOK = 7;
  localparam int ST_RECV = 6;
  localparam int ST_CRC  = 5;
  localparam int ST_FSE  = 4;

endpackage

// File: rtl/dorx_frame_mark.sv
// Detects a run of MARK_W strobed bits forming the start mark (seek_end=0)
// or its complement with the reference channel low (seek_end=1).
module dorx_frame_mark #(
  parameter int MARK_W = 4,
  parameter logic [MARK_W-1:0] MARK = 4'b0001
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_en,
  input  logic seek_end,
  input  logic light,
  input  logic ir,
  output logic hit
);
  localparam int CNT_W = $clog2(MARK_W + 1);

  logic [MARK_W-1:0] hist_q;
  logic [CNT_W-1:0]  run_q;
  logic [MARK_W-1:0] window;
  logic [MARK_W-1:0] want;
  logic              ir_ok;

  assign window = {hist_q[MARK_W-2:0], light};
  assign want   = seek_end ? ~MARK : MARK;
  assign ir_ok  = (ir == ~seek_end);
  assign hit    = bit_en && ir_ok && (run_q >= CNT_W'(MARK_W - 1)) && (window == want);

  always_ff @(posedge clk) begin
    if (rst || clr || hit) begin
      hist_q <= '0;
      run_q  <= '0;
    end else if (bit_en) begin
      if (ir_ok) begin
        hist_q <= window;
        if (run_q != CNT_W'(MARK_W - 1)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

endmodule

// File: rtl/dorx_crc_serial.sv
// Bit-serial polynomial remainder, no augmentation: a message that already
// carries its check bytes leaves a zero remainder.
module dorx_crc_serial #(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] rem
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem <= '0;
    end else if (step) begin
      rem <= {rem[CRC_W-2:0], din} ^ (rem[CRC_W-1] ? POLY : '0);
    end
  end
endmodule

// File: rtl/dual_optic_rx.sv
module dual_optic_rx
  import dorx_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 128,
  parameter int CTRL_W = 16,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter int MARK_W = 4,
  parameter logic [MARK_W-1:0] MARK = 4'b0001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 light_in,
  input  logic                 ir_in,
  input  logic                 ctrl_wr,
  input  logic [CTRL_W-1:0]    ctrl_wdata,
  input  logic                 stat_clr,
  output logic [CTRL_W-1:0]    ctrl_rd,
  output logic [LEN_W+3:0]     status,
  output logic [CTRL_W-1:0]    rx_id,
  output logic [DATA_W-1:0]    rx_data
);
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = CRC_W / 8 + 1;
  localparam logic [CTRL_W-1:0] CW_MASK = CTRL_W'((1 << (CW_AUTO + 1)) - 1);

  phase_t            ph_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ID_W-1:0]   target_q;
  logic [ID_W-1:0]   id_sh_q;
  logic [LEN_W-1:0]  len_sh_q;
  logic [LEN_W-1:0]  len_q;
  logic              id_ok_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W+3:0]  status_q;
  logic [CTRL_W-1:0] rxid_q;
  logic [DATA_W-1:0] data_q;

  logic              mismatch, hunting, mark_hit, sof_hit;
  logic [ID_W-1:0]   id_full;
  logic [LEN_W-1:0]  len_full;
  logic [CNT_W-1:0]  data_bits;
  logic [IDX_W-1:0]  wr_pos;
  logic              take_data, data_last;
  logic [CRC_W-1:0]  crc_rem;

  assign mismatch  = light_in ^ ir_in;
  assign hunting   = (ph_q == PH_SEEK_SOF) || (ph_q == PH_SEEK_EOF);
  assign sof_hit   = (ph_q == PH_SEEK_SOF) && mark_hit;
  assign id_full   = {id_sh_q[ID_W-2:0], light_in};
  assign len_full  = {len_sh_q[LEN_W-2:0], light_in};
  assign data_bits = CNT_W'({len_q, 3'b000});
  assign wr_pos    = IDX_W'(DATA_W - 1) - cnt_q[IDX_W-1:0];
  assign take_data = (ph_q == PH_DATA) && bit_en && !mismatch && (cnt_q < data_bits);
  assign data_last = take_data && ((cnt_q + 1'b1) == data_bits) && (len_q >= LEN_W'(MIN_LEN));

  dorx_frame_mark #(.MARK_W(MARK_W), .MARK(MARK)) u_mark (
    .clk      (clk),
    .rst      (rst),
    .clr      (!hunting),
    .bit_en   (bit_en),
    .seek_end (ph_q == PH_SEEK_EOF),
    .light    (light_in),
    .ir       (ir_in),
    .hit      (mark_hit)
  );

  dorx_crc_serial #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk  (clk),
    .rst  (rst),
    .clr  (sof_hit),
    .step (take_data),
    .din  (light_in),
    .rem  (crc_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      ctrl_q   <= '0;
      target_q <= '0;
      id_sh_q  <= '0;
      len_sh_q <= '0;
      len_q    <= '0;
      id_ok_q  <= 1'b0;
      cnt_q    <= '0;
      status_q <= '0;
      rxid_q   <= '0;
      data_q   <= '0;
    end else begin
      if (stat_clr) status_q <= '0;

      if (!ctrl_q[CW_RUN]) begin
        ph_q <= PH_IDLE;
      end else begin
        case (ph_q)
          PH_IDLE: ph_q <= PH_SEEK_SOF;

          PH_SEEK_SOF: if (mark_hit) begin
            ph_q    <= PH_ID;
            cnt_q   <= '0;
            id_ok_q <= 1'b0;
            len_q   <= '0;
            data_q  <= '0;
          end

          PH_ID, PH_LEN, PH_DATA: if (bit_en) begin
            if (mismatch) begin
              status_q <= {id_ok_q, 1'b0, 1'b0, 1'b1, len_q};
              ph_q     <= PH_SEEK_SOF;
            end else if (ph_q == PH_ID) begin
              id_sh_q <= id_full;
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(ID_W - 1)) begin
                cnt_q  <= '0;
                rxid_q <= CTRL_W'(id_full);
                if (id_full == target_q) begin
                  id_ok_q <= 1'b1;
                  ph_q    <= PH_LEN;
                end else begin
                  status_q <= '0;
                  ph_q     <= PH_SEEK_SOF;
                end
              end
            end else if (ph_q == PH_LEN) begin
              len_sh_q <= len_full;
              cnt_q    <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(LEN_W - 1)) begin
                cnt_q <= '0;
                len_q <= len_full;
                ph_q  <= PH_DATA;
              end
            end else if (take_data) begin
              data_q[wr_pos] <= light_in;
              cnt_q          <= cnt_q + 1'b1;
              if (data_last) ph_q <= PH_SEEK_EOF;
            end
          end

          PH_SEEK_EOF: if (mark_hit) begin
            status_q <= {1'b1, 1'b1, |crc_rem, 1'b0, len_q};
            if (ctrl_q[CW_AUTO]) begin
              ph_q <= PH_SEEK_SOF;
            end else begin
              ctrl_q[CW_RUN] <= 1'b0;
              ph_q           <= PH_IDLE;
            end
          end

          default: ph_q <= PH_IDLE;
        endcase
      end

      if (ctrl_wr) begin
        ctrl_q <= ctrl_wdata & CW_MASK;
        if (ctrl_wdata[CW_LOAD]) target_q <= ctrl_wdata[ID_W-1:0];
      end
    end
  end

  assign ctrl_rd = ctrl_q;
  assign status  = status_q;
  assign rx_id   = rxid_q;
  assign rx_data = data_q;

endmodule

// File: rtl/dual_optic_rx_chk.sv
module dual_optic_rx_chk #(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              stat_clr,
  input logic              ctrl_wr,
  input logic              run_bit,
  input logic              auto_bit,
  input logic [LEN_W+3:0]  status,
  input logic [DATA_W-1:0] rx_data
);
  localparam int RECV = LEN_W + 2;
  localparam int IDOK = LEN_W + 3;
  localparam int CRCE = LEN_W + 1;
  localparam int FSE  = LEN_W;

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !stat_clr) |=> $stable(status)) else $error("status moved"); // R11

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(rx_data)) else $error("data moved"); // R12

  AST_RECV_NO_FSE: assert property (@(posedge clk) disable iff (rst)
    status[RECV] |-> (!status[FSE] && status[IDOK])) else $error("recv flags"); // R7

  AST_RECV_LEN_MIN: assert property (@(posedge clk) disable iff (rst)
    status[RECV] |-> (status[LEN_W-1:0] >= LEN_W'(3))) else $error("short len"); // R9

  AST_CRC_ONLY_RECV: assert property (@(posedge clk) disable iff (rst)
    status[CRCE] |-> status[RECV]) else $error("crc flag"); // R6

  AST_RUN_DROP: assert property (@(posedge clk) disable iff (rst)
    (run_bit && !ctrl_wr) |=> (run_bit || status[RECV])) else $error("run drop"); // R10

  AST_AUTO_KEEP: assert property (@(posedge clk) disable iff (rst)
    (run_bit && auto_bit && !ctrl_wr) |=> run_bit) else $error("auto run"); // R10

endmodule

bind dual_optic_rx dual_optic_rx_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_en   (bit_en),
  .stat_clr (stat_clr),
  .ctrl_wr  (ctrl_wr),
  .run_bit  (ctrl_rd[dorx_pkg::CW_RUN]),
  .auto_bit (ctrl_rd[dorx_pkg::CW_AUTO]),
  .status   (status),
  .rx_data  (rx_data)
);

// File: tb/tb_dual_optic_rx.sv
`timescale 1ns/1ps
module tb_dual_optic_rx;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_en = 1'b0;
  logic         light_in = 1'b0;
  logic         ir_in = 1'b0;
  logic         ctrl_wr = 1'b0;
  logic [15:0]  ctrl_wdata = '0;
  logic         stat_clr = 1'b0;
  logic [15:0]  ctrl_rd;
  logic [7:0]   status;
  logic [15:0]  rx_id;
  logic [127:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [10:0] TGT   = 11'h4D3;
  localparam logic [15:0] W_AUTO = 16'h2000;
  localparam logic [15:0] W_RUN  = 16'h1000;
  localparam logic [15:0] W_LOAD = 16'h0800;

  always #4 clk = ~clk;

  dual_optic_rx dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .light_in(light_in), .ir_in(ir_in),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .stat_clr(stat_clr),
    .ctrl_rd(ctrl_rd), .status(status), .rx_id(rx_id), .rx_data(rx_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobed bit, then one unstrobed cycle with inverted channels (R12)
  task automatic send_bit(input logic l, input logic i);
    @(negedge clk);
    light_in = l; ir_in = i; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; light_in = ~l; ir_in = ~i;
  endtask

  task automatic wr_ctrl(input logic [15:0] w);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = w;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic send_start();
    send_bit(1'b1, 1'b0);   // disagreement while hunting: ignored (R8)
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b1);
    send_bit(1'b0, 1'b1);
    send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
  endtask

  task automatic send_stop();
    send_bit(1'b0, 1'b1);   // ignored in stop hunt
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
  endtask

  task automatic send_id(input logic [10:0] id);
    for (int i = 10; i >= 0; i--) send_bit(id[i], id[i]);
  endtask

  task automatic send_len(input logic [3:0] len);
    for (int i = 3; i >= 0; i--) send_bit(len[i], len[i]);
  endtask

  function automatic logic [7:0] pat(input int seed, input int b);
    return 8'((seed * 29 + b * 53 + 17) & 255);
  endfunction

  // data field with bench-computed CRC; fills expected rx_data
  task automatic send_body(input int len, input int seed, input bit bad,
                           output logic [127:0] exp);
    logic [15:0] crc;
    logic [7:0]  by;
    logic        b;
    int          k;
    int          nd;
    crc = '0; k = 0; exp = '0;
    nd = (len >= 3) ? len - 2 : len;
    for (int j = 0; j < nd; j++) begin
      by = pat(seed, j);
      for (int i = 7; i >= 0; i--) begin
        b = by[i];
        crc = {crc[14:0], 1'b0} ^ ((crc[15] ^ b) ? 16'h1021 : 16'h0000);
        exp[127 - k] = b; k++;
        send_bit(b, b);
      end
    end
    if (len >= 3) begin
      crc = crc ^ (bad ? 16'h0001 : 16'h0000);
      for (int i = 15; i >= 0; i--) begin
        exp[127 - k] = crc[i]; k++;
        send_bit(crc[i], crc[i]);
      end
    end
  endtask

  task automatic frame(input logic [10:0] id, input int len, input int seed,
                       input bit bad, output logic [127:0] exp);
    send_start();
    send_id(id);
    send_len(4'(len));
    send_body(len, seed, bad, exp);
    send_stop();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] exp;
    logic [7:0]   st_before;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status", 128'(status), 128'h0);
    chk("R1 rx_id", 128'(rx_id), 128'h0);
    chk("R1 rx_data", rx_data, 128'h0);
    chk("R1 ctrl_rd", 128'(ctrl_rd), 128'h0);

    // R2: top bits dropped, load latches target
    wr_ctrl(16'hC000 | W_LOAD | 16'(TGT));
    chk("R2 readback", 128'(ctrl_rd), 128'(W_LOAD | 16'(TGT)));

    // R3: run clear -> no reception
    frame(TGT, 5, 1, 0, exp);
    chk("R3 no run status", 128'(status), 128'h0);
    chk("R3 no run rx_id", 128'(rx_id), 128'h0);

    // sweep every length code, good and bad CRC
    for (int len = 0; len < 16; len++) begin
      for (int bad = 0; bad < 2; bad++) begin
        if (len < 3 && bad == 1) continue;
        clear_status();
        chk("R11 cleared", 128'(status), 128'h0);
        wr_ctrl(W_RUN | 16'(TGT));   // load bit clear: target kept (R2)
        frame(TGT, len, len + bad, bad[0], exp);
        chk("R4 rx_id", 128'(rx_id), 128'({5'b0, TGT}));
        chk("R5 rx_data", rx_data, exp);
        if (len >= 3) begin
          chk("R7 R6 status", 128'(status), 128'({2'b11, bad[0], 1'b0, 4'(len)}));
          chk("R10 run cleared", 128'(ctrl_rd[12]), 128'h0);
        end else begin
          chk("R9 short len status", 128'(status), 128'({4'b1001, 4'(len)}));
          chk("R9 run kept", 128'(ctrl_rd[12]), 128'h1);
        end
        st_before = status;
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        chk("R11 status held", 128'(status), 128'(st_before));
      end
    end

    // R4: ID mismatch
    wr_ctrl(W_RUN | 16'(TGT));
    send_start();
    send_id(TGT ^ 11'h001);
    chk("R4 mismatch status", 128'(status), 128'h00);
    chk("R4 mismatch rx_id", 128'(rx_id), 128'({5'b0, TGT ^ 11'h001}));
    chk("R4 run kept", 128'(ctrl_rd[12]), 128'h1);
    send_len(4'd4);
    send_body(4, 9, 0, exp);
    send_stop();
    chk("R4 leftover ignored", 128'(status), 128'h00);
    wr_ctrl(W_RUN | 16'(TGT));
    frame(TGT, 4, 3, 0, exp);
    chk("R4 recovery", 128'(status), 128'hC4);

    // R8: disagreement in data, id, length phases
    wr_ctrl(W_RUN | 16'(TGT));
    send_start(); send_id(TGT); send_len(4'd6);
    for (int i = 0; i < 10; i++) send_bit(i[0], i[0]);
    send_bit(1'b1, 1'b0);
    chk("R8 abort data", 128'(status), 128'h96);
    chk("R8 run kept", 128'(ctrl_rd[12]), 128'h1);
    send_start();
    send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b1);
    chk("R8 abort id", 128'(status), 128'h10);
    send_start(); send_id(TGT);
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0);
    chk("R8 abort len", 128'(status), 128'h90);
    frame(TGT, 3, 5, 0, exp);
    chk("R8 recovery", 128'(status), 128'hC3);
    chk("R8 recovery data", rx_data, exp);

    // R10: auto-rearm, back-to-back frames
    wr_ctrl(W_AUTO | W_RUN | 16'(TGT));
    frame(TGT, 5, 11, 0, exp);
    chk("R10 auto frame1", 128'(status), 128'hC5);
    chk("R10 auto run", 128'(ctrl_rd), 128'(W_AUTO | W_RUN | 16'(TGT)));
    frame(TGT, 7, 12, 1, exp);
    chk("R10 auto frame2", 128'(status), 128'hE7);
    chk("R10 auto data", rx_data, exp);

    // R10: clearing run returns to idle from a stuck short frame
    wr_ctrl(W_RUN | 16'(TGT));
    send_start(); send_id(TGT); send_len(4'd1);
    wr_ctrl(16'(TGT));
    wr_ctrl(W_RUN | 16'(TGT));
    frame(TGT, 6, 13, 0, exp);
    chk("R10 run clear exits", 128'(status), 128'hC6);

    // R12: unstrobed start mark and ID bits do nothing
    clear_status();
    wr_ctrl(W_RUN | 16'(TGT));
    st_before = rx_id[7:0];
    @(negedge clk); light_in = 0; ir_in = 1;
    repeat (3) @(negedge clk);
    light_in = 1;
    @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      light_in = ~TGT[i % 11]; ir_in = ~TGT[i % 11];
      @(negedge clk);
    end
    chk("R12 status", 128'(status), 128'h0);
    chk("R12 rx_id", 128'(rx_id[7:0]), 128'(st_before));
    chk("R12 run", 128'(ctrl_rd[12]), 128'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule